// File: doc/BRIEF.md
# I2C Control Unit with Clock Stretch and Bit-Rate Generator

This block is the sequencing and status core of a byte-oriented I2C engine. It gathers events from the bus condition detector, the byte shifter and the address matcher. When one of them needs software attention, it raises an interrupt flag and, one cycle later, publishes a status code that names the event. For as long as the flag stays up, it holds SCL low, so the bus waits while software decides what to do next.

Software drives the block through a five-bit control write. The write carries enable, acknowledge-enable, a start command, a stop command and a write-one-to-clear bit for the flag. While the unit owns the bus as master, a prescaled divider produces SCL. One SCL period lasts 16 + 2·div·4^pre system clocks, where `div` is an eight-bit divider input and `pre` is a two-bit prescale input. The pad drivers and the full slave data path live outside this unit.

Top module: `i2cCtlUnit`

## Requirements
- R1: After reset, `flag` is 0, `status` is 0xF8, and `sclLow` and `sdaLow` are 0.
- R2: An accepted event sets `flag` at the next clock edge. During the first cycle with `flag` high, `status` still reads 0xF8. The event code appears one edge later.
- R3: Whenever `flag` is 0, `status` reads 0xF8.
- R4: The status codes are:
  - 0x08: START sent.
  - 0x10: START sent again after an earlier START, with no stop command or arbitration loss in between.
  - 0x18 / 0x20: address byte sent, with acknowledge / no acknowledge (`ackIn` = 1 / 0).
  - 0x28 / 0x30: data byte done, with acknowledge / no acknowledge.
  - 0x60: own address matched.
  - 0x38: arbitration lost.
- R5: When several events arrive in the same cycle, the winner is chosen in this order: arbitration lost, then START, then address, then data, then own-address match.
- R6: Events that arrive while `flag` is set are ignored. The flag and the status code keep their values.
- R7: A control write with bit 4 = 1 clears `flag`, and `status` returns to 0xF8 at the same edge. A write with bit 4 = 0 leaves `flag` set.
- R8: `sclLow` is 1 during every cycle in which `flag` is 1.
- R9: A write with bit 2 = 1 (start command) makes the unit own the bus. SCL then runs with a period of 16 + 2·div·4^pre clocks. A write with bit 1 = 1 (stop command) releases SCL.
- R10: A control write with bit 0 = 0 (enable) has these effects at the next edge:
  - `flag` returns to 0 and `status` to 0xF8.
  - `sclLow` and `sdaLow` return to 0.
  - Bus ownership is dropped.
  - Events presented while the unit is disabled set no flag.
- R11: `sdaLow` is 1 only while the flag holds code 0x60 and acknowledge-enable (bit 3) is 1.
- R12: Arbitration loss drops bus ownership. Once the flag is cleared, SCL stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control write strobe |
| wrData | input | 5 | Control bits: 4 clear flag, 3 ack enable, 2 start, 1 stop, 0 enable |
| bitDiv | input | 8 | Bit-rate divider |
| bitPre | input | 2 | Bit-rate prescale exponent |
| evStart | input | 1 | START or repeated START has been sent |
| evAddr | input | 1 | Address plus R/W byte has been sent |
| evData | input | 1 | Data byte has been sent or received |
| evMatch | input | 1 | Own address has been matched |
| evArbLost | input | 1 | Arbitration has been lost |
| ackIn | input | 1 | Acknowledge bit that came with an address or data event |
| flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| sclLow | output | 1 | Pull SCL low |
| sdaLow | output | 1 | Pull SDA low to acknowledge |

## Verification
A code register holding a stale value shows up on `status` one edge after the flag rises, and the bench compares every event combination against a priority model at that edge. A lost repeated-START tracker shows as 0x08 where 0x10 was due on the next START. A divider off by one count moves each measured SCL rising edge by two cycles, which is visible within one period. A stretch or enable path that fails to act shows as `sclLow` or `flag` with the wrong level in the very cycle after the flag or the control write.

// File: rtl/i2cCtlPkg.sv
package i2cCtlPkg;
  localparam int CTL_W = 5;
  localparam int EN_B  = 0;
  localparam int STO_B = 1;
  localparam int STA_B = 2;
  localparam int ACK_B = 3;
  localparam int CLR_B = 4;
  localparam int ST_W  = 8;

  localparam logic [ST_W-1:0] ST_START    = 8'h08;
  localparam logic [ST_W-1:0] ST_RSTART   = 8'h10;
  localparam logic [ST_W-1:0] ST_ADDR_ACK = 8'h18;
  localparam logic [ST_W-1:0] ST_ADDR_NAK = 8'h20;
  localparam logic [ST_W-1:0] ST_DATA_ACK = 8'h28;
  localparam logic [ST_W-1:0] ST_DATA_NAK = 8'h30;
  localparam logic [ST_W-1:0] ST_ARB_LOST = 8'h38;
  localparam logic [ST_W-1:0] ST_OWN_HIT  = 8'h60;
  localparam logic [ST_W-1:0] ST_NO_INFO  = 8'hF8;

  typedef struct packed {
    logic clear;
    logic hold;
    logic run;
    logic setCode;
    logic dropCode;
  } ctlStrobeT;
endpackage

// File: rtl/i2cCtlControl.sv
module i2cCtlControl
  import i2cCtlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             evStart,
  input  logic             evAddr,
  input  logic             evData,
  input  logic             evMatch,
  input  logic             evArbLost,
  input  logic             ackIn,
  output logic             flag,
  output logic [ST_W-1:0]  codeOut,
  output logic             ackDrive,
  output ctlStrobeT        strobes
);
  logic enQ, ackEnQ, flagQ, ownQ, inXferQ, setDlyQ;
  logic [ST_W-1:0] codeQ;
  logic enNext, clrWr, evAny, accept;
  logic winStart, winArb;
  logic [ST_W-1:0] nextCode;

  assign enNext = wrEn ? wrData[EN_B] : enQ;
  assign clrWr  = wrEn && wrData[CLR_B];
  assign evAny  = evArbLost | evStart | evAddr | evData | evMatch;
  assign accept = enQ && enNext && !flagQ && evAny;

  // fixed priority among simultaneous events
  always_comb begin
    winStart = 1'b0;
    winArb   = 1'b0;
    if (evArbLost) begin
      nextCode = ST_ARB_LOST;
      winArb   = 1'b1;
    end else if (evStart) begin
      nextCode = inXferQ ? ST_RSTART : ST_START;
      winStart = 1'b1;
    end else if (evAddr) begin
      nextCode = ackIn ? ST_ADDR_ACK : ST_ADDR_NAK;
    end else if (evData) begin
      nextCode = ackIn ? ST_DATA_ACK : ST_DATA_NAK;
    end else begin
      nextCode = ST_OWN_HIT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      ackEnQ  <= 1'b0;
      flagQ   <= 1'b0;
      ownQ    <= 1'b0;
      inXferQ <= 1'b0;
      setDlyQ <= 1'b0;
      codeQ   <= ST_NO_INFO;
    end else if (!enNext) begin
      enQ     <= 1'b0;
      ackEnQ  <= wrEn ? wrData[ACK_B] : ackEnQ;
      flagQ   <= 1'b0;
      ownQ    <= 1'b0;
      inXferQ <= 1'b0;
      setDlyQ <= 1'b0;
    end else begin
      enQ     <= 1'b1;
      setDlyQ <= accept && !clrWr;
      if (wrEn) ackEnQ <= wrData[ACK_B];
      if (clrWr) begin
        flagQ <= 1'b0;
      end else if (accept) begin
        flagQ <= 1'b1;
        codeQ <= nextCode;
      end
      if (accept && winStart) inXferQ <= 1'b1;
      if (wrEn && wrData[STA_B]) ownQ <= 1'b1;
      if ((accept && winArb) || (wrEn && wrData[STO_B])) begin
        ownQ    <= 1'b0;
        inXferQ <= 1'b0;
      end
    end
  end

  assign flag     = flagQ;
  assign codeOut  = codeQ;
  assign ackDrive = flagQ && ackEnQ && (codeQ == ST_OWN_HIT);

  always_comb begin
    strobes.clear    = !enNext;
    strobes.hold     = flagQ;
    strobes.run      = ownQ && enQ;
    strobes.setCode  = setDlyQ;
    strobes.dropCode = flagQ && clrWr;
  end
endmodule

// File: rtl/i2cCtlDatapath.sv
module i2cCtlDatapath
  import i2cCtlPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeT        strobes,
  input  logic [ST_W-1:0]  code,
  input  logic [DIV_W-1:0] bitDiv,
  input  logic [PRE_W-1:0] bitPre,
  output logic [ST_W-1:0]  status,
  output logic             sclLow
);
  localparam int MAX_SHIFT = 2 * ((1 << PRE_W) - 1);
  localparam int CNT_W     = DIV_W + MAX_SHIFT + 5;

  logic [CNT_W-1:0] halfLen, cnt;
  logic [ST_W-1:0]  statusQ;
  logic             sclHighQ;

  // half period = 8 + div * 4^pre
  assign halfLen = CNT_W'(8) + (CNT_W'(bitDiv) << {bitPre, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= ST_NO_INFO;
    end else if (strobes.clear || strobes.dropCode) begin
      statusQ <= ST_NO_INFO;
    end else if (strobes.setCode) begin
      statusQ <= code;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      sclHighQ <= 1'b1;
    end else if (strobes.clear) begin
      cnt      <= '0;
      sclHighQ <= 1'b1;
    end else if (strobes.hold) begin
      cnt      <= '0;
      sclHighQ <= 1'b0;
    end else if (!strobes.run) begin
      cnt      <= '0;
      sclHighQ <= 1'b1;
    end else if (cnt == halfLen - CNT_W'(1)) begin
      cnt      <= '0;
      sclHighQ <= !sclHighQ;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign status = statusQ;
  assign sclLow = strobes.hold || !sclHighQ;
endmodule

// File: rtl/i2cCtlUnit.sv
module i2cCtlUnit
  import i2cCtlPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic [DIV_W-1:0] bitDiv,
  input  logic [PRE_W-1:0] bitPre,
  input  logic             evStart,
  input  logic             evAddr,
  input  logic             evData,
  input  logic             evMatch,
  input  logic             evArbLost,
  input  logic             ackIn,
  output logic             flag,
  output logic [ST_W-1:0]  status,
  output logic             sclLow,
  output logic             sdaLow
);
  ctlStrobeT       strobes;
  logic [ST_W-1:0] code;

  i2cCtlControl ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .evStart(evStart), .evAddr(evAddr), .evData(evData),
    .evMatch(evMatch), .evArbLost(evArbLost), .ackIn(ackIn),
    .flag(flag), .codeOut(code), .ackDrive(sdaLow), .strobes(strobes)
  );

  i2cCtlDatapath #(.DIV_W(DIV_W), .PRE_W(PRE_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .code(code),
    .bitDiv(bitDiv), .bitPre(bitPre), .status(status), .sclLow(sclLow)
  );
endmodule

// File: rtl/i2cCtlChecker.sv
module i2cCtlChecker
  import i2cCtlPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CTL_W-1:0] wrData,
  input logic             flag,
  input logic [ST_W-1:0]  status,
  input logic             sclLow,
  input logic             sdaLow
);
  // R3
  status_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flag |-> status == ST_NO_INFO);

  // R8
  scl_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    flag |-> sclLow);

  // R2
  code_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flag) && !wrEn) |=> status != ST_NO_INFO);

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && $past(flag) && !wrEn) |=> $stable(status));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && wrEn && wrData[CLR_B] && wrData[EN_B]) |=> !flag);

  // R7
  write_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && wrEn && !wrData[CLR_B] && wrData[EN_B]) |=> flag);

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[EN_B]) |=> (!flag && !sclLow && !sdaLow && status == ST_NO_INFO));

  // R11
  sda_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaLow |-> flag);
endmodule

bind i2cCtlUnit i2cCtlChecker chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .flag(flag), .status(status), .sclLow(sclLow), .sdaLow(sdaLow)
);

// File: tb/i2cCtlUnit_test.sv
`timescale 1ns/1ps
module i2cCtlUnit_test;
  localparam logic [4:0] EN = 5'h01, STOP = 5'h02, START = 5'h04, ACK = 5'h08, CLR = 5'h10;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [4:0] wrData = 0;
  logic [7:0] bitDiv = 0;
  logic [1:0] bitPre = 0;
  logic evStart = 0, evAddr = 0, evData = 0, evMatch = 0, evArbLost = 0, ackIn = 0;
  logic flag, sclLow, sdaLow;
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit inx = 0;
  logic [4:0] base;

  i2cCtlUnit uut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    wrEn = 1; wrData = d;
    cyc();
    wrEn = 0;
  endtask

  task automatic pulse(input logic [4:0] m, input logic a);
    {evArbLost, evStart, evAddr, evData, evMatch} = m;
    ackIn = a;
    cyc();
    {evArbLost, evStart, evAddr, evData, evMatch} = 5'h0;
  endtask

  function automatic int expCode(input logic [4:0] m, input logic a, input bit ix);
    if (m[4]) return 'h38;
    if (m[3]) return ix ? 'h10 : 'h08;
    if (m[2]) return a ? 'h18 : 'h20;
    if (m[1]) return a ? 'h28 : 'h30;
    return 'h60;
  endfunction

  task automatic fire(input logic [4:0] m, input logic a, input string req);
    int exp;
    exp = expCode(m, a, inx);
    pulse(m, a);
    check({req, " R2 flag set"}, flag, 1);
    check({req, " R2 status before code"}, status, 'hF8);
    cyc();
    check({req, " R4 R5 code"}, status, exp);
    check({req, " R8 stretch"}, sclLow, 1);
    check({req, " R11 sda"}, sdaLow, (base[3] && exp == 'h60) ? 1 : 0);
    pulse(5'h1F, 1'b1);
    check({req, " R6 status kept"}, status, exp);
    check({req, " R6 flag kept"}, flag, 1);
    wr(base);
    check({req, " R7 write0 keeps flag"}, flag, 1);
    wr(base | CLR);
    check({req, " R7 flag cleared"}, flag, 0);
    check({req, " R3 idle status"}, status, 'hF8);
    if (m[4]) inx = 0;
    else if (m[3]) inx = 1;
  endtask

  task automatic measure(input int dv, input int pr);
    bit prev;
    int n;
    bitDiv = 8'(dv); bitPre = 2'(pr);
    wr(base | START);
    prev = sclLow;
    for (int i = 0; i < 3000; i++) begin
      cyc();
      if (!prev && sclLow) break;
      prev = sclLow;
    end
    prev = sclLow;
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      cyc();
      n++;
      if (!prev && sclLow) break;
      prev = sclLow;
    end
    check($sformatf("R9 period div=%0d pre=%0d", dv, pr), n, 16 + 2 * dv * (4 ** pr));
    wr(base | STOP);
    cyc();
    check("R9 stop releases scl", sclLow, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ones;
    repeat (3) cyc();
    rstN = 1;
    cyc();
    check("R1 flag", flag, 0);
    check("R1 status", status, 'hF8);
    check("R1 scl", sclLow, 0);
    check("R1 sda", sdaLow, 0);

    base = EN | ACK;
    wr(base);
    fire(5'b01000, 0, "start");
    fire(5'b01000, 0, "rstart");
    fire(5'b00100, 1, "addr ack");
    fire(5'b00100, 0, "addr nak");
    fire(5'b00010, 1, "data ack");
    fire(5'b00010, 0, "data nak");
    fire(5'b00001, 0, "match ack");
    fire(5'b10000, 0, "arb");
    base = EN;
    wr(base);
    fire(5'b00001, 0, "match noack R11");
    base = EN | ACK;
    wr(base);

    for (int m = 1; m < 32; m++)
      fire(5'(m), 1'(m & 1), $sformatf("sweep %0d R5", m));

    for (int pr = 0; pr < 4; pr++)
      foreach (bitDiv[k]) if (k < 4) measure((k == 3) ? 5 : k, pr);

    // R12 arbitration loss drops ownership
    bitDiv = 0; bitPre = 0;
    wr(base | START);
    pulse(5'b10000, 0);
    cyc();
    check("R12 arb code", status, 'h38);
    wr(base | CLR);
    cyc();
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (sclLow) ones++;
    end
    check("R12 scl released", ones, 0);

    // R10 disable
    wr(base | START);
    pulse(5'b00001, 0);
    check("R10 flag before disable", flag, 1);
    wr(5'h00);
    check("R10 flag", flag, 0);
    check("R10 status", status, 'hF8);
    check("R10 scl", sclLow, 0);
    check("R10 sda", sdaLow, 0);
    pulse(5'b01000, 0);
    check("R10 event ignored", flag, 0);
    wr(base);
    repeat (40) begin
      cyc();
      if (sclLow) ones++;
    end
    check("R10 ownership dropped", ones, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule